// File: doc/BRIEF.md
# Sigma-Delta Bitstream Counting Decimator

This block reduces the one-bit comparator stream of a first-order sigma-delta loop to a signed conversion result. The stream is sampled on an oversampling tick. A prescaler makes that tick by dividing the master clock by 1, 2 or 4. On every tick an up/down accumulator moves by +1 for a high bit and by -1 for a low bit. The accumulator therefore integrates the duty cycle of the stream over a programmable window.

A conversion starts on a `start` pulse while the block is idle. The divider selection and the window code are captured at that pulse. At the end of the window the accumulated count is scaled to a 14-bit result and checked against full scale. It is then packed into a 16-bit word and loaded into a static result register, and `done` pulses for one cycle.

The result word is laid out as follows:
- bit 15: sign
- bit 14: overrange flag
- bits 13:0: data

An `abort` input ends a conversion early. It discards the partial count and leaves the result register untouched.

Top module: `sd_count_decim`

## Requirements
- R1: The tick spacing is set by `div_sel` as captured at start: 0 gives 1 cycle, 1 gives 2 cycles, and 2 or 3 give 4 cycles.
- R2: On each tick the accumulator adds 1 when `bit_in` is 1 and subtracts 1 when it is 0. A stream of H high bits in every P ticks therefore gives a count of N·(2H−P)/P.
- R3: The window length N in ticks is 10·2^code, where code is `len_code` as captured at start. Code 12 with divide-by-2 gives 81,920 master cycles.
- R4: The count is normalised so that ±0.8·N maps to ±16384. The scaled value is count·2^(11−code), computed as an arithmetic shift. A 7-high / 3-low stream therefore gives +8192, which is half scale.
- R5: The result word carries the sign in bit 15, the overrange flag in bit 14, and data in bits 13:0. Together, bit 15 and bits 13:0 form the scaled value as a 15-bit two's complement number.
- R6: A scaled value above +16383 gives 16'h7FFF. A value below −16384 gives 16'hC000. Exactly −16384 is in range and gives 16'h8000.
- R7: `result` changes only in the cycle where `done` is high. `done` is a single-cycle pulse in the cycle after the last tick.
- R8: `busy` is high from the cycle after an accepted start for N·div cycles, and is low while `done` is high. A `start` pulse that arrives while busy, together with any change of `div_sel` or `len_code`, has no effect.
- R9: Asserting `abort` drops `busy` on the next cycle, produces no `done`, and leaves `result` unchanged. The next conversion counts from zero. `abort` takes priority over `start`.
- R10: After reset, `busy` and `done` are 0 and `result` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion when idle |
| abort | input | 1 | Cancel the running conversion |
| div_sel | input | 2 | Prescaler select: 0 → /1, 1 → /2, 2 or 3 → /4 |
| len_code | input | 4 | Window code, N = 10·2^code ticks |
| bit_in | input | 1 | Comparator bitstream |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is loaded |
| result | output | 16 | {sign, overrange, data[13:0]} |

## Verification

The bench drives periodic bitstreams whose duty cycle is exact over the window, whatever the tick phase:
- 7/10 and 3/10 separate the sign handling at half scale.
- 5/10 checks the zero point.
- 1/4 checks a non-decade duty at a different window length.
- 9/10, 1/10, all-ones and all-zeros probe both edges of full scale. They show that +0.8·N overranges while −0.8·N does not.

Each divider setting, including the alias code 3, is combined with a different window code. The busy length therefore confirms the tick spacing and the window size separately. A start issued mid-conversion, together with changed settings, and an abort followed by a fresh conversion show that the captured settings persist and that the count restarts from zero.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int DATA_W      = 14;
  localparam int WORD_W      = DATA_W + 2;
  localparam int CODE_W      = 4;
  localparam int MAX_CODE    = (1 << CODE_W) - 1;
  localparam int BASE_TICKS  = 10;
  localparam int FS_PER_BASE = 8;
  localparam int SHIFT_REF   = DATA_W - $clog2(FS_PER_BASE);
  localparam int ACC_W       = $clog2(BASE_TICKS << MAX_CODE) + 2;
  localparam int SEL_W       = 2;
  localparam int PRE_W       = 2;
  localparam int POS_MAX     = (1 << DATA_W) - 1;
  localparam int NEG_MIN     = -(1 << DATA_W);

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [WORD_W-1:0]       word_t;
  typedef logic [CODE_W-1:0]       code_t;

  // Master clocks per oversampling tick.
  function automatic int div_factor(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Window length in ticks for a code.
  function automatic acc_t ticks_for_code(input code_t code);
    return acc_t'(BASE_TICKS << code);
  endfunction

  // Scale a raw count so that 0.8*N maps to 2**DATA_W.
  function automatic logic signed [31:0] normalise(input acc_t cnt, input code_t code);
    logic signed [31:0] wide;
    wide = {{(32-ACC_W){cnt[ACC_W-1]}}, cnt};
    if (int'(code) <= SHIFT_REF)
      return wide <<< (SHIFT_REF - int'(code));
    else
      return wide >>> (int'(code) - SHIFT_REF);
  endfunction

  // Pack into {sign, overrange, data}, saturating when out of range.
  function automatic word_t pack_word(input logic signed [31:0] v);
    if (v > POS_MAX)
      return {1'b0, 1'b1, {DATA_W{1'b1}}};
    else if (v < NEG_MIN)
      return {1'b1, 1'b1, {DATA_W{1'b0}}};
    else
      return {v[31], 1'b0, v[DATA_W-1:0]};
  endfunction
endpackage

// File: rtl/sdd_prescaler.sv
module sdd_prescaler
  import sdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel_q,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(div_factor(div_sel_q) - 1);
  assign tick  = run && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (clear) pcnt <= '0;
    else if (run)   pcnt <= tick ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/sdd_window.sv
module sdd_window
  import sdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [SEL_W-1:0] div_sel,
  input  code_t            len_code,
  input  logic             bit_in,
  input  logic             tick,
  output logic             busy,
  output logic             go,
  output logic             last,
  output acc_t             acc,
  output acc_t             acc_end,
  output code_t            code_q,
  output logic [SEL_W-1:0] div_sel_q
);
  acc_t left;
  acc_t step;

  assign go      = start && !busy && !abort;
  assign step    = bit_in ? acc_t'(1) : acc_t'(-1);
  assign acc_end = acc + step;
  assign last    = busy && tick && !abort && (left == acc_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      acc       <= '0;
      left      <= '0;
      code_q    <= '0;
      div_sel_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      acc  <= '0;
      left <= '0;
    end else if (go) begin
      busy      <= 1'b1;
      acc       <= '0;
      left      <= ticks_for_code(len_code);
      code_q    <= len_code;
      div_sel_q <= div_sel;
    end else if (busy && tick) begin
      acc  <= acc_end;
      left <= left - acc_t'(1);
      if (left == acc_t'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sdd_result.sv
module sdd_result
  import sdd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  acc_t  acc_end,
  input  code_t code_q,
  output word_t result,
  output logic  done
);
  word_t packed_w;

  assign packed_w = pack_word(normalise(acc_end, code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= load;
      if (load) result <= packed_w;
    end
  end
endmodule

// File: rtl/sd_count_decim.sv
module sd_count_decim
  import sdd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic [1:0]  div_sel,
  input  logic [3:0]  len_code,
  input  logic        bit_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] result
);
  // Internal events brought out for the checker.
  logic             tick_w;
  logic             go_w;
  logic             last_w;
  acc_t             acc_w;
  acc_t             acc_end_w;
  code_t            code_q_w;
  logic [SEL_W-1:0] div_q_w;
  logic             busy_w;

  sdd_window win_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .div_sel(div_sel), .len_code(len_code), .bit_in(bit_in),
    .tick(tick_w), .busy(busy_w), .go(go_w), .last(last_w),
    .acc(acc_w), .acc_end(acc_end_w), .code_q(code_q_w),
    .div_sel_q(div_q_w)
  );

  sdd_prescaler pre_i (
    .clk(clk), .rst_n(rst_n), .clear(go_w || abort), .run(busy_w),
    .div_sel_q(div_q_w), .tick(tick_w)
  );

  sdd_result res_i (
    .clk(clk), .rst_n(rst_n), .load(last_w), .acc_end(acc_end_w),
    .code_q(code_q_w), .result(result), .done(done)
  );

  assign busy = busy_w;
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker
  import sdd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             abort,
  input logic             bit_in,
  input logic             busy,
  input logic             done,
  input logic [15:0]      result,
  input logic             tick,
  input logic             go,
  input logic             last,
  input acc_t             acc,
  input code_t            code_q,
  input logic [SEL_W-1:0] div_q
);
  logic [2:0] gap;
  acc_t       tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      tcnt <= '0;
    end else begin
      gap  <= (go || tick) ? 3'd0 : gap + 3'd1;
      if (go)        tcnt <= '0;
      else if (tick) tcnt <= tcnt + acc_t'(1);
    end
  end

  // R1: ticks arrive exactly div cycles apart
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == 3'(div_factor(div_q) - 1)));

  // R2: accumulator moves in the direction of the sampled bit
  assert_step_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy && !abort && !last) |=>
      ($past(bit_in) ? (acc > $past(acc)) : (acc < $past(acc))));

  // R3: the last tick is the N-th one
  assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (tcnt == ticks_for_code(code_q) - acc_t'(1)));

  // R6: overrange words are saturated
  assert_ovr_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[14]) |-> (result[13:0] == (result[15] ? 14'h0000 : 14'h3FFF)));

  // R7: result is static outside done
  assert_result_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R7: done is a single pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done ends a busy period
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8: an accepted start raises busy
  assert_go_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R9: abort stops the conversion without a result
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));
endmodule

bind sd_count_decim sdd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .abort(abort), .bit_in(bit_in),
  .busy(busy), .done(done), .result(result), .tick(tick_w),
  .go(go_w), .last(last_w), .acc(acc_w), .code_q(code_q_w),
  .div_q(div_q_w)
);

// File: tb/sd_count_decim_tb_top.sv
module sd_count_decim_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic [3:0]  len_code = 4'd0;
  logic        bit_in;
  logic        busy;
  logic        done;
  logic [15:0] result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int hi_n = 1;
  int per_n = 2;
  int dv_n = 1;
  int ph = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sd_count_decim dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .div_sel(div_sel), .len_code(len_code), .bit_in(bit_in),
    .busy(busy), .done(done), .result(result)
  );

  // Periodic bitstream: high for hi_n of every per_n ticks, in master cycles.
  always @(negedge clk) ph <= (ph + 1 >= per_n * dv_n) ? 0 : ph + 1;
  assign bit_in = (ph < hi_n * dv_n);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model(input int code, input int h, input int p);
    longint n, c, s;
    logic [15:0] w;
    n = 64'(10) << code;
    c = (n / p) * (2 * h - p);
    s = (c * 2048) / (64'(1) << code);
    if (s > 16383)       w = 16'h7FFF;
    else if (s < -16384) w = 16'hC000;
    else                 w = {s < 0, 1'b0, s[13:0]};
    return w;
  endfunction

  // Monitor: compare each produced result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", int'(result), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result == e, t, int'(result), int'(e));
      end
    end
  end

  task automatic run_conv(input logic [1:0] ds, input int code, input int h,
                          input int p, input bit poke, input string tag);
    int n;
    int dv;
    dv = (ds == 2'd0) ? 1 : (ds == 2'd1) ? 2 : 4;
    hi_n = h; per_n = p; dv_n = dv;
    exp_q.push_back(model(code, h, p));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b1; div_sel = ds; len_code = 4'(code);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (poke && n == 3) begin start = 1'b1; len_code = 4'd0; div_sel = 2'd0; end
      if (poke && n == 4) start = 1'b0;
      @(negedge clk);
    end
    check(n == (10 << code) * dv, "R1 R3 R8 busy length", n, (10 << code) * dv);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] saved;
    int dn;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0 && done == 1'b0, "R10 flags after reset", int'({busy, done}), 0);
    check(result == 16'h0000, "R10 result after reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_conv(2'd0, 0, 7, 10, 0, "R4 half scale 7/10");
    run_conv(2'd1, 1, 3, 10, 0, "R5 negative half scale 3/10");
    run_conv(2'd0, 0, 5, 10, 0, "R2 zero 5/10");
    run_conv(2'd2, 2, 9, 10, 0, "R6 plus full scale overranges");
    run_conv(2'd0, 1, 1, 10, 0, "R6 minus full scale in range");
    run_conv(2'd3, 3, 0, 1, 0, "R6 all zeros saturate");
    run_conv(2'd0, 1, 1, 4, 0, "R2 duty 1/4");
    run_conv(2'd1, 3, 7, 10, 1, "R8 start while busy ignored");

    // R9: abort mid-conversion
    saved = result;
    hi_n = 1; per_n = 1; dv_n = 1;
    @(negedge clk);
    start = 1'b1; div_sel = 2'd0; len_code = 4'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(busy == 1'b0, "R9 busy low after abort", int'(busy), 0);
    dn = 0;
    repeat (60) begin
      @(negedge clk);
      if (done) dn++;
    end
    check(dn == 0, "R9 no done after abort", dn, 0);
    check(result == saved, "R9 R7 result kept after abort", int'(result), int'(saved));

    run_conv(2'd0, 0, 1, 1, 0, "R9 fresh count after abort");
    run_conv(2'd1, 12, 7, 10, 0, "R3 long window 81920 cycles");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 every conversion produced done", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule